// File: doc/BRIEF.md
# Windowed 64-bit Register Access Bridge

This block sits as a target on a 32-bit register bus and lets a host reach a bank of 64-bit registers behind it. The host fills two 32-bit staging words with the upper and lower halves of a value. It then writes a command word that names an internal address and says whether to read or write. That single command write launches exactly one 64-bit access on an internal request/acknowledge bus. On a read, the returned value lands back in the two staging words, so the host fetches it with two ordinary 32-bit reads.

Any failure is kept in a sticky error flag that the host inspects after each command. A failure is a target address outside the configured internal range, which the bridge refuses without touching the internal bus, or an error reported by the internal responder. A write to a dedicated clear register removes the flag. An enable bit lets the flag drive an interrupt line. While an access is in flight a busy flag is shown, and further commands are dropped.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, both staging words, the command readback, the status word and the interrupt enable read as zero, and `int_req` is low.
- R2: Host writes to offset 0x00 (upper half, bits 63:32) and 0x04 (lower half, bits 31:0) are read back unchanged and never raise `int_req` by themselves.
- R3: A write to offset 0x08 with bit 31 set, while idle and with bits 30:0 below `ADDR_LIMIT`, raises `int_req` in the next cycle with `int_we`=1, `int_addr` = bits 30:0 and `int_wdata` = {word 0x00, word 0x04} as they stood at the command write.
- R4: The same command with bit 31 clear performs a read. On the acknowledge cycle without error, word 0x00 takes `int_rdata[63:32]` and word 0x04 takes `int_rdata[31:0]`.
- R5: From the cycle after an accepted command until the cycle after `int_ack`, status bit 0 (busy) reads 1 and `int_req` stays high with stable address, direction and data. Command writes in that window are ignored, and offset 0x08 keeps reading the accepted command.
- R6: A command whose bits 30:0 are at or above `ADDR_LIMIT` never raises `int_req` and sets status bit 31 in the next cycle.
- R7: `int_err` on the acknowledge cycle sets status bit 31, and a read so answered leaves both staging words unchanged.
- R8: Status bit 31 stays set until a host write to offset 0x18. When a new error arrives in the same cycle as that write, the flag stays set.
- R9: Bit 0 of offset 0x20 is a read/write interrupt enable, and `irq` equals status bit 31 AND that enable.
- R10: When a read acknowledge and a host write to a staging word fall in the same cycle, the read data wins.
- R11: Offsets other than 0x00, 0x04, 0x08, 0x18, 0x1C and 0x20 read as zero, and writes to them change nothing. Offset 0x18 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | Host access is a write |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | WORD_W | Host write data |
| host_rdata | output | WORD_W | Host read data (combinational from host_addr) |
| int_req | output | 1 | Internal access outstanding |
| int_we | output | 1 | Internal access is a write |
| int_addr | output | WORD_W-1 | Internal register address |
| int_wdata | output | 2*WORD_W | Internal write value |
| int_ack | input | 1 | Internal access completes this cycle |
| int_err | input | 1 | Internal access failed (valid with int_ack) |
| int_rdata | input | 2*WORD_W | Internal read value (valid with int_ack) |
| irq | output | 1 | Error interrupt |

## Verification
The hardest situations to reach are the ones where two events land on the same clock edge. One is a read acknowledge in the cycle the host writes a staging word. The other is a response error in the cycle the host writes the clear register. The bench reaches them by writing the relevant offset on every cycle while watching its own acknowledge line, and it stops one cycle after the acknowledge. Holding the responder's latency over several cycles also places a second command inside the busy window, which shows that the command is dropped.

// File: rtl/wrb_pkg.sv
// Shared definitions for the windowed 64-bit register bridge.
// Assumes host offsets fit in 8 bits; decode sizes them to HOST_AW.
package wrb_pkg;
    localparam logic [7:0] OFS_WORD_HI = 8'h00;
    localparam logic [7:0] OFS_WORD_LO = 8'h04;
    localparam logic [7:0] OFS_CMD     = 8'h08;
    localparam logic [7:0] OFS_CLEAR   = 8'h18;
    localparam logic [7:0] OFS_STATUS  = 8'h1C;
    localparam logic [7:0] OFS_IRQ_EN  = 8'h20;

    typedef enum logic {ENG_IDLE = 1'b0, ENG_WAIT = 1'b1} eng_state_t;

    typedef struct packed {
        logic wr_hi;
        logic wr_lo;
        logic wr_cmd;
        logic wr_clear;
        logic wr_irq_en;
    } host_strobes_t;
endpackage

// File: rtl/wrb_host_decode.sv
// Host write decoder: turns one host bus write into a per-register strobe.
// Assumes at most one host access per cycle; unmapped offsets give no strobe.
module wrb_host_decode
    import wrb_pkg::*;
#(
    parameter int HOST_AW = 8
) (
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    output host_strobes_t      strobes
);
    logic do_write;
    assign do_write = host_sel & host_wr;

    // Compare the offset against each mapped register
    always_comb begin
        strobes           = '0;
        strobes.wr_hi     = do_write && (host_addr == HOST_AW'(OFS_WORD_HI));
        strobes.wr_lo     = do_write && (host_addr == HOST_AW'(OFS_WORD_LO));
        strobes.wr_cmd    = do_write && (host_addr == HOST_AW'(OFS_CMD));
        strobes.wr_clear  = do_write && (host_addr == HOST_AW'(OFS_CLEAR));
        strobes.wr_irq_en = do_write && (host_addr == HOST_AW'(OFS_IRQ_EN));
    end
endmodule

// File: rtl/wrb_engine.sv
// Access engine: accepts a command word, range-checks it, and runs one
// wide access on the internal request/acknowledge bus.
// Assumes the responder raises int_ack for one cycle while int_req is high;
// int_err and int_rdata are only looked at in that cycle.
module wrb_engine
    import wrb_pkg::*;
#(
    parameter int          WORD_W     = 32,
    parameter int unsigned ADDR_LIMIT = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_strobe,
    input  logic [WORD_W-1:0]   cmd_word,
    input  logic [WORD_W-1:0]   stage_hi,
    input  logic [WORD_W-1:0]   stage_lo,
    output logic                int_req,
    output logic                int_we,
    output logic [WORD_W-2:0]   int_addr,
    output logic [2*WORD_W-1:0] int_wdata,
    input  logic                int_ack,
    input  logic                int_err,
    output logic                busy,
    output logic                accept,
    output logic                reject,
    output logic                load_rd,
    output logic                resp_err
);
    localparam int IADDR_W = WORD_W - 1;
    localparam int WIDE_W  = 2 * WORD_W;

    eng_state_t             state_q;
    logic                   we_q;
    logic [IADDR_W-1:0]     addr_q;
    logic [WIDE_W-1:0]      wdata_q;
    logic                   in_range;
    logic                   ack_seen;

    // Range check on the address field of the command
    assign in_range = ({1'b0, cmd_word[IADDR_W-1:0]} < WORD_W'(ADDR_LIMIT));
    assign busy     = (state_q == ENG_WAIT);
    assign accept   = cmd_strobe && !busy && in_range;
    assign reject   = cmd_strobe && !busy && !in_range;
    assign ack_seen = busy && int_ack;
    assign load_rd  = ack_seen && !we_q && !int_err;
    assign resp_err = ack_seen && int_err;

    // Sequence the idle/wait states and capture the access on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (accept) begin
                        state_q <= ENG_WAIT;
                        we_q    <= cmd_word[WORD_W-1];
                        addr_q  <= cmd_word[IADDR_W-1:0];
                        wdata_q <= {stage_hi, stage_lo};
                    end
                end
                ENG_WAIT: begin
                    if (int_ack) state_q <= ENG_IDLE;
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign int_req   = busy;
    assign int_we    = we_q;
    assign int_addr  = addr_q;
    assign int_wdata = wdata_q;
endmodule

// File: rtl/wrb_err_track.sv
// Error tracker: sticky error flag with host clear, plus interrupt enable.
// A new error in the same cycle as a clear keeps the flag set.
module wrb_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic set_local,
    input  logic set_remote,
    input  logic clear,
    input  logic en_strobe,
    input  logic en_value,
    output logic err_flag,
    output logic irq_en,
    output logic irq
);
    logic err_q;
    logic en_q;

    // Hold the error until cleared; a set outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (err_q && !clear) || set_local || set_remote;
    end

    // Keep the interrupt enable bit written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (en_strobe) en_q <= en_value;
    end

    assign err_flag = err_q;
    assign irq_en   = en_q;
    assign irq      = err_q && en_q;
endmodule

// File: rtl/wide_reg_bridge.sv
// Top level: 32-bit host register window onto a 64-bit internal bus.
// Holds the staging words and the command readback, and serves host reads
// combinationally from host_addr. Assumes a single host master.
module wide_reg_bridge
    import wrb_pkg::*;
#(
    parameter int          WORD_W     = 32,
    parameter int          HOST_AW    = 8,
    parameter int unsigned ADDR_LIMIT = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_sel,
    input  logic                  host_wr,
    input  logic [HOST_AW-1:0]    host_addr,
    input  logic [WORD_W-1:0]     host_wdata,
    output logic [WORD_W-1:0]     host_rdata,
    output logic                  int_req,
    output logic                  int_we,
    output logic [WORD_W-2:0]     int_addr,
    output logic [2*WORD_W-1:0]   int_wdata,
    input  logic                  int_ack,
    input  logic                  int_err,
    input  logic [2*WORD_W-1:0]   int_rdata,
    output logic                  irq
);
    localparam int WIDE_W = 2 * WORD_W;

    host_strobes_t      strb;
    logic [WORD_W-1:0]  data_hi_q;
    logic [WORD_W-1:0]  data_lo_q;
    logic [WORD_W-1:0]  cmd_q;
    logic               busy;
    logic               accept;
    logic               reject;
    logic               load_rd;
    logic               resp_err;
    logic               err_q;
    logic               irq_en;

    wrb_host_decode #(.HOST_AW(HOST_AW)) u_decode (
        .host_sel (host_sel),
        .host_wr  (host_wr),
        .host_addr(host_addr),
        .strobes  (strb)
    );

    wrb_engine #(.WORD_W(WORD_W), .ADDR_LIMIT(ADDR_LIMIT)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_strobe(strb.wr_cmd),
        .cmd_word  (host_wdata),
        .stage_hi  (data_hi_q),
        .stage_lo  (data_lo_q),
        .int_req   (int_req),
        .int_we    (int_we),
        .int_addr  (int_addr),
        .int_wdata (int_wdata),
        .int_ack   (int_ack),
        .int_err   (int_err),
        .busy      (busy),
        .accept    (accept),
        .reject    (reject),
        .load_rd   (load_rd),
        .resp_err  (resp_err)
    );

    wrb_err_track u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_local (reject),
        .set_remote(resp_err),
        .clear     (strb.wr_clear),
        .en_strobe (strb.wr_irq_en),
        .en_value  (host_wdata[0]),
        .err_flag  (err_q),
        .irq_en    (irq_en),
        .irq       (irq)
    );

    // Upper staging word: read data outranks a host write
    always_ff @(posedge clk) begin
        if (!rst_n)          data_hi_q <= '0;
        else if (load_rd)    data_hi_q <= int_rdata[WIDE_W-1:WORD_W];
        else if (strb.wr_hi) data_hi_q <= host_wdata;
    end

    // Lower staging word: read data outranks a host write
    always_ff @(posedge clk) begin
        if (!rst_n)          data_lo_q <= '0;
        else if (load_rd)    data_lo_q <= int_rdata[WORD_W-1:0];
        else if (strb.wr_lo) data_lo_q <= host_wdata;
    end

    // Command readback holds the last accepted or refused command
    always_ff @(posedge clk) begin
        if (!rst_n)                  cmd_q <= '0;
        else if (accept || reject)   cmd_q <= host_wdata;
    end

    // Host read multiplexer
    always_comb begin
        host_rdata = '0;
        if (host_addr == HOST_AW'(OFS_WORD_HI))      host_rdata = data_hi_q;
        else if (host_addr == HOST_AW'(OFS_WORD_LO)) host_rdata = data_lo_q;
        else if (host_addr == HOST_AW'(OFS_CMD))     host_rdata = cmd_q;
        else if (host_addr == HOST_AW'(OFS_STATUS))
            host_rdata = {err_q, {(WORD_W-2){1'b0}}, busy};
        else if (host_addr == HOST_AW'(OFS_IRQ_EN))
            host_rdata = {{(WORD_W-1){1'b0}}, irq_en};
    end
endmodule

// File: rtl/wrb_checker.sv
// Property checker for wide_reg_bridge, attached with bind below.
// Decodes host writes on its own from the host port.
module wrb_checker #(
    parameter int          WORD_W     = 32,
    parameter int          HOST_AW    = 8,
    parameter int unsigned ADDR_LIMIT = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_sel,
    input logic                host_wr,
    input logic [HOST_AW-1:0]  host_addr,
    input logic [WORD_W-1:0]   host_wdata,
    input logic                int_req,
    input logic                int_we,
    input logic [WORD_W-2:0]   int_addr,
    input logic [2*WORD_W-1:0] int_wdata,
    input logic                int_ack,
    input logic                int_err,
    input logic [2*WORD_W-1:0] int_rdata,
    input logic                err_flag,
    input logic [WORD_W-1:0]   data_hi,
    input logic [WORD_W-1:0]   data_lo
);
    logic cmd_wr;
    logic clr_wr;
    logic addr_ok;
    assign cmd_wr  = host_sel && host_wr && (host_addr == HOST_AW'(8'h08));
    assign clr_wr  = host_sel && host_wr && (host_addr == HOST_AW'(8'h18));
    assign addr_ok = ({1'b0, host_wdata[WORD_W-2:0]} < WORD_W'(ADDR_LIMIT));

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_req && !cmd_wr) |=> !int_req);

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !int_req && addr_ok) |=>
        (int_req && int_addr == $past(host_wdata[WORD_W-2:0])
                 && int_we == $past(host_wdata[WORD_W-1])));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack && !int_we && !int_err) |=>
        (data_hi == $past(int_rdata[2*WORD_W-1:WORD_W])
         && data_lo == $past(int_rdata[WORD_W-1:0])));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=>
        (int_req && $stable(int_addr) && $stable(int_we) && $stable(int_wdata)));

    assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !int_req && !addr_ok) |=> (!int_req && err_flag));

    assert_resp_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack && int_err) |=> err_flag);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_wr) |=> err_flag);
endmodule

bind wide_reg_bridge wrb_checker #(
    .WORD_W(WORD_W), .HOST_AW(HOST_AW), .ADDR_LIMIT(ADDR_LIMIT)
) u_wrb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .int_req   (int_req),
    .int_we    (int_we),
    .int_addr  (int_addr),
    .int_wdata (int_wdata),
    .int_ack   (int_ack),
    .int_err   (int_err),
    .int_rdata (int_rdata),
    .err_flag  (err_q),
    .data_hi   (data_hi_q),
    .data_lo   (data_lo_q)
);

// File: tb/wide_reg_bridge_bench.sv
// Bench: behavioural memory responder, per-cycle reference model, directed tests.
module wide_reg_bridge_bench;
    localparam int LIMIT = 32;
    localparam int BANK  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        int_req, int_we, irq;
    logic [30:0] int_addr;
    logic [63:0] int_wdata;
    logic        int_ack = 1'b0;
    logic        int_err = 1'b0;
    logic [63:0] int_rdata = '0;

    int errors = 0;
    int checks = 0;
    int lat_cfg = 0;
    int cnt = 0;
    int cyc = 0;
    logic [63:0] mem [BANK];

    always #10 clk = ~clk;

    wide_reg_bridge #(.WORD_W(32), .HOST_AW(8), .ADDR_LIMIT(LIMIT)) u_wide_reg_bridge (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
        .int_ack(int_ack), .int_err(int_err), .int_rdata(int_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // Memory responder: entries 0..BANK-1 exist, BANK..LIMIT-1 answer with an error
    always @(negedge clk) begin
        if (int_ack) begin
            int_ack = 1'b0;
            int_err = 1'b0;
        end else if (rst_n && int_req) begin
            if (cnt == 0) begin
                int_ack = 1'b1;
                int_err = (int_addr >= 31'(BANK));
                if (!int_err) begin
                    if (int_we) mem[int_addr[3:0]] = int_wdata;
                    int_rdata = mem[int_addr[3:0]];
                end else int_rdata = 64'hBAD0BAD0BAD0BAD0;
                cnt = lat_cfg;
            end else cnt--;
        end else cnt = lat_cfg;
    end

    // Reference model of host-visible state
    logic [31:0] m_hi, m_lo, m_cmd;
    logic        m_busy, m_err, m_ien, m_we;
    logic [30:0] m_addr;
    logic [63:0] m_wdata;
    always @(posedge clk) begin
        logic hw, acc, ld;
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_cmd = 0; m_busy = 0; m_err = 0; m_ien = 0;
            m_we = 0; m_addr = 0; m_wdata = 0;
        end else begin
            hw  = host_sel && host_wr;
            acc = hw && host_addr == 8'h08 && !m_busy;
            ld  = 0;
            if (m_busy && int_ack) begin
                m_busy = 0;
                if (!m_we && !int_err) ld = 1;
            end
            if (hw && host_addr == 8'h18) m_err = 0;
            if (m_busy == 0 && int_ack && int_err) m_err = 1;
            if (ld) begin m_hi = int_rdata[63:32]; m_lo = int_rdata[31:0]; end
            else if (hw && host_addr == 8'h00) m_hi = host_wdata;
            else if (hw && host_addr == 8'h04) m_lo = host_wdata;
            if (hw && host_addr == 8'h20) m_ien = host_wdata[0];
            if (acc) begin
                m_cmd = host_wdata;
                if (host_wdata[30:0] >= 31'(LIMIT)) m_err = 1;
                else begin
                    m_busy = 1; m_we = host_wdata[31]; m_addr = host_wdata[30:0];
                    m_wdata = {m_hi, m_lo};
                end
            end
        end
    end
    // Note: m_hi/m_lo used for m_wdata above are the pre-edge values only when no
    // data write collides with a command, which cannot happen in one host cycle.

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_hi;
            8'h04: return m_lo;
            8'h08: return m_cmd;
            8'h1C: return {m_err, 30'b0, m_busy};
            8'h20: return {31'b0, m_ien};
            default: return 32'h0;
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R5 req", int_req, m_busy);
            if (m_busy) begin
                check("R3 we", int_we, m_we);
                check("R3 addr", int_addr, m_addr);
                check("R3 wdata", int_wdata, m_wdata);
            end
            check("R9 irq", irq, m_err & m_ien);
            check("R11 rdata", host_rdata, model_read(host_addr));
        end
    end

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk); #2;
        host_sel = 0; host_wr = 0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); #2;
        host_addr = a;
        #3 v = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 50; i++) begin
            hread(8'h1C, v);
            if (!v[0]) break;
        end
    endtask

    // Write one offset every cycle until the cycle carrying the acknowledge
    task automatic hammer(input logic [7:0] a, input logic [31:0] d);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #2;
            host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
            if (int_ack) break;
        end
        @(negedge clk); #2;
        host_sel = 0; host_wr = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < BANK; i++) mem[i] = {32'hA5A50000 + i, 32'h5A5A0000 + i};
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        hread(8'h00, v); check("R1 hi", v, 0);
        hread(8'h04, v); check("R1 lo", v, 0);
        hread(8'h08, v); check("R1 cmd", v, 0);
        hread(8'h1C, v); check("R1 status", v, 0);
        hread(8'h20, v); check("R1 ien", v, 0);
        check("R1 req", int_req, 0);
        // R2 staging words, no access
        hwrite(8'h00, 32'hDEADBEEF);
        hwrite(8'h04, 32'h01234567);
        check("R2 no req", int_req, 0);
        hread(8'h00, v); check("R2 hi", v, 32'hDEADBEEF);
        hread(8'h04, v); check("R2 lo", v, 32'h01234567);
        // R3 write
        hwrite(8'h08, 32'h8000_0003);
        wait_idle();
        check("R3 mem", mem[3], 64'hDEADBEEF_01234567);
        // R4 read
        hwrite(8'h00, 0); hwrite(8'h04, 0);
        lat_cfg = 3;
        hwrite(8'h08, 32'h0000_0009);
        wait_idle();
        hread(8'h00, v); check("R4 hi", v, 32'hA5A50009);
        hread(8'h04, v); check("R4 lo", v, 32'h5A5A0009);
        // R5 busy and ignored command
        lat_cfg = 6;
        hwrite(8'h08, 32'h0000_0002);
        hread(8'h1C, v); check("R5 busy", v[0], 1);
        hwrite(8'h08, 32'h8000_0005);
        hread(8'h08, v); check("R5 cmd kept", v, 32'h0000_0002);
        wait_idle();
        check("R5 mem5 untouched", mem[5], {32'hA5A50005, 32'h5A5A0005});
        hread(8'h00, v); check("R5 read result", v, 32'hA5A50002);
        // R6 out of range
        lat_cfg = 1;
        hwrite(8'h08, 32'h0000_0028);
        check("R6 no req", int_req, 0);
        hread(8'h1C, v); check("R6 err", v, 32'h8000_0000);
        // R9 interrupt
        hwrite(8'h20, 1);
        check("R9 irq on", irq, 1);
        // R8 sticky through a good access, then clear
        hwrite(8'h08, 32'h0000_0001);
        wait_idle();
        hread(8'h1C, v); check("R8 sticky", v, 32'h8000_0000);
        hwrite(8'h18, 0);
        hread(8'h1C, v); check("R8 cleared", v, 0);
        check("R9 irq off", irq, 0);
        // R7 response error leaves data
        hwrite(8'h00, 32'h13572468);
        hwrite(8'h08, 32'h0000_0014);
        wait_idle();
        hread(8'h1C, v); check("R7 err", v[31], 1);
        hread(8'h00, v); check("R7 data kept", v, 32'h13572468);
        hwrite(8'h18, 0);
        // R8 set wins over clear in the same cycle
        lat_cfg = 2;
        hwrite(8'h08, 32'h0000_0015);
        hammer(8'h18, 0);
        hread(8'h1C, v); check("R8 set wins", v, 32'h8000_0000);
        hwrite(8'h18, 0);
        // R10 read data wins over host write
        hwrite(8'h08, 32'h0000_0007);
        hammer(8'h00, 32'h11111111);
        hread(8'h00, v); check("R10 hi", v, 32'hA5A50007);
        // R11 unmapped
        hwrite(8'h30, 32'hFFFFFFFF);
        hread(8'h30, v); check("R11 unmapped", v, 0);
        hread(8'h18, v); check("R11 clear reads zero", v, 0);
        hread(8'h04, v); check("R11 lo unchanged", v, 32'h5A5A0007);
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule